// File: doc/BRIEF.md
# Operand Forwarding Selector

This block chooses the two ALU operands, and the store data, for the instruction that sits in the execute stage of a five-stage integer pipeline. It looks at the instruction words held in the ID/EX, EX/MEM and MEM/WB pipeline registers. From their opcodes it works out which older instructions will write a register, and which register each one writes. When an operand register of the execute-stage instruction matches a pending write, it returns the newer value from a pipeline register in place of the stale register-file read.

The block is purely combinational. It has no clock, no state and no handshake. Every output is a function of the current inputs and is ready in the same cycle those inputs are presented. The caller supplies the register-file read data for rs and rt. It also supplies the result held in EX/MEM, and the value MEM/WB will write back, which is either the loaded data or the ALU result. Load-use stalls are left to the hazard logic that sits around this block.

Top module: `operand_fwd_unit`

## Requirements
- R1: The opcode is bits [31:26], with rs at [25:21], rt at [20:16], rd at [15:11] and the immediate at [15:0]. Opcode classes: 000000 is register-register ALU, 001xxx is immediate ALU, 100xxx is load, 101xxx is store, 0001xx is branch, and any other opcode is "other".
- R2: A register-register instruction in EX/MEM forwards `exmem_result` to any consumer whose source register equals its rd.
- R3: An immediate-ALU producer is matched on its rt field and never on rd. A load in MEM/WB is matched on rt and forwards `memwb_result`.
- R4: A load in EX/MEM never forwards.
- R5: When EX/MEM and MEM/WB both match the same source register, the EX/MEM value is selected.
- R6: A match on register 0 never forwards. The register-file value is used instead.
- R7: The rs operand (`alu_a`) is forwarded for consumers of the register-register, immediate, load, store and branch classes. An "other" consumer always gets `rf_rs_data`.
- R8: `alu_b` is the forwarded rt value for register-register consumers. For every other consumer it is the immediate, sign-extended to DATA_W.
- R9: `store_data` is the forwarded rt value for store consumers. For every other consumer it is `rf_rt_data`.
- R10: Store, branch and "other" producers never forward, whatever their field bits hold.
- R11: Every output follows a change on any input within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_instr | input | 32 | Instruction word of the consumer (ID/EX) |
| exmem_instr | input | 32 | Instruction word held in EX/MEM |
| memwb_instr | input | 32 | Instruction word held in MEM/WB |
| rf_rs_data | input | DATA_W | Register-file read for rs |
| rf_rt_data | input | DATA_W | Register-file read for rt |
| exmem_result | input | DATA_W | ALU result held in EX/MEM |
| memwb_result | input | DATA_W | Write-back value held in MEM/WB |
| alu_a | output | DATA_W | Upper ALU operand |
| alu_b | output | DATA_W | Lower ALU operand |
| store_data | output | DATA_W | Data for a store |

## Verification
Every result is due zero cycles after its stimulus, because no register sits between any input and any output. The bench changes inputs on the falling clock edge and samples the outputs a few nanoseconds later, inside the same half period. No sampled value can therefore depend on an edge. For R11, one directed test changes the forwarded data a second time within a single cycle and confirms that the output follows before the next edge.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  typedef enum logic [2:0] {
    CL_OTHER,
    CL_RR,
    CL_IMM,
    CL_LOAD,
    CL_STORE,
    CL_BRANCH
  } op_class_e;

  localparam int OPC_W = 6;
  localparam int REG_W = 5;

  function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
    op_class_e c;
    casez (opc)
      6'b000000: c = CL_RR;
      6'b001???: c = CL_IMM;
      6'b100???: c = CL_LOAD;
      6'b101???: c = CL_STORE;
      6'b0001??: c = CL_BRANCH;
      default:   c = CL_OTHER;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/opfwd_producer_dec.sv
module opfwd_producer_dec
  import opfwd_pkg::*;
#(
  parameter bit LOAD_READY = 1'b0
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_reg
);

  op_class_e cls;
  logic      writes;

  assign cls = classify(opc);

  always_comb begin
    writes = 1'b0;
    wr_reg = '0;
    unique case (cls)
      CL_RR:   begin writes = 1'b1;       wr_reg = rd; end
      CL_IMM:  begin writes = 1'b1;       wr_reg = rt; end
      CL_LOAD: begin writes = LOAD_READY; wr_reg = rt; end
      default: begin writes = 1'b0;       wr_reg = '0; end
    endcase
  end

  // register 0 is hard-wired to zero: never a forwarding target
  assign wr_en = writes && (wr_reg != '0);

endmodule

// File: rtl/opfwd_consumer_dec.sv
module opfwd_consumer_dec
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instr,
  output logic              use_rs,
  output logic              use_rt,
  output logic              is_rr,
  output logic              is_store,
  output logic [REG_W-1:0]  rs,
  output logic [REG_W-1:0]  rt,
  output logic [DATA_W-1:0] imm_sext
);

  localparam int EXT_W = DATA_W - 16;

  op_class_e cls;

  assign cls      = classify(instr[31:26]);
  assign rs       = instr[25:21];
  assign rt       = instr[20:16];
  assign imm_sext = {{EXT_W{instr[15]}}, instr[15:0]};

  assign is_rr    = (cls == CL_RR);
  assign is_store = (cls == CL_STORE);
  assign use_rs   = (cls != CL_OTHER);
  assign use_rt   = is_rr || is_store;

endmodule

// File: rtl/opfwd_src_sel.sv
module opfwd_src_sel
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              want,
  input  logic [REG_W-1:0]  src_reg,
  input  logic              near_we,
  input  logic [REG_W-1:0]  near_reg,
  input  logic              far_we,
  input  logic [REG_W-1:0]  far_reg,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] near_data,
  input  logic [DATA_W-1:0] far_data,
  output logic [DATA_W-1:0] value
);

  logic hit_near, hit_far;

  assign hit_near = want && near_we && (near_reg == src_reg);
  assign hit_far  = want && far_we  && (far_reg  == src_reg);

  // the newer producer (EX/MEM) takes priority
  always_comb begin
    if (hit_near)     value = near_data;
    else if (hit_far) value = far_data;
    else              value = rf_data;
  end

endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       idex_instr,
  input  logic [31:0]       exmem_instr,
  input  logic [31:0]       memwb_instr,
  input  logic [DATA_W-1:0] rf_rs_data,
  input  logic [DATA_W-1:0] rf_rt_data,
  input  logic [DATA_W-1:0] exmem_result,
  input  logic [DATA_W-1:0] memwb_result,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  output logic [DATA_W-1:0] store_data
);

  localparam int N_OPND = 2;

  logic             em_we, mw_we;
  logic [REG_W-1:0] em_reg, mw_reg;

  // a load in EX/MEM has no data yet; a load in MEM/WB does
  opfwd_producer_dec #(.LOAD_READY(1'b0)) u_em_dec (
    .opc(exmem_instr[31:26]), .rt(exmem_instr[20:16]), .rd(exmem_instr[15:11]),
    .wr_en(em_we), .wr_reg(em_reg)
  );

  opfwd_producer_dec #(.LOAD_READY(1'b1)) u_mw_dec (
    .opc(memwb_instr[31:26]), .rt(memwb_instr[20:16]), .rd(memwb_instr[15:11]),
    .wr_en(mw_we), .wr_reg(mw_reg)
  );

  logic              use_rs, use_rt, is_rr, is_store;
  logic [REG_W-1:0]  rs, rt;
  logic [DATA_W-1:0] imm_sext;

  opfwd_consumer_dec #(.DATA_W(DATA_W)) u_cons (
    .instr(idex_instr), .use_rs(use_rs), .use_rt(use_rt), .is_rr(is_rr),
    .is_store(is_store), .rs(rs), .rt(rt), .imm_sext(imm_sext)
  );

  logic              want   [N_OPND];
  logic [REG_W-1:0]  srcreg [N_OPND];
  logic [DATA_W-1:0] rfval  [N_OPND];
  logic [DATA_W-1:0] fwdval [N_OPND];

  assign want[0]   = use_rs;
  assign srcreg[0] = rs;
  assign rfval[0]  = rf_rs_data;
  assign want[1]   = use_rt;
  assign srcreg[1] = rt;
  assign rfval[1]  = rf_rt_data;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    opfwd_src_sel #(.DATA_W(DATA_W)) u_sel (
      .want(want[g]), .src_reg(srcreg[g]),
      .near_we(em_we), .near_reg(em_reg),
      .far_we(mw_we), .far_reg(mw_reg),
      .rf_data(rfval[g]), .near_data(exmem_result), .far_data(memwb_result),
      .value(fwdval[g])
    );
  end

  assign alu_a      = fwdval[0];
  assign alu_b      = is_rr ? fwdval[1] : imm_sext;
  assign store_data = is_store ? fwdval[1] : rf_rt_data;

endmodule

// File: rtl/opfwd_checker.sv
module opfwd_checker #(
  parameter int DATA_W = 32
) (
  input logic [31:0]       idex_instr,
  input logic [31:0]       exmem_instr,
  input logic [31:0]       memwb_instr,
  input logic [DATA_W-1:0] rf_rs_data,
  input logic [DATA_W-1:0] rf_rt_data,
  input logic [DATA_W-1:0] exmem_result,
  input logic [DATA_W-1:0] memwb_result,
  input logic [DATA_W-1:0] alu_a,
  input logic [DATA_W-1:0] alu_b,
  input logic [DATA_W-1:0] store_data
);

  logic [5:0] c_op, e_op, w_op;
  logic       known, e_silent, w_silent;

  assign c_op = idex_instr[31:26];
  assign e_op = exmem_instr[31:26];
  assign w_op = memwb_instr[31:26];
  assign known = !$isunknown({idex_instr, exmem_instr, memwb_instr});
  assign e_silent = !(e_op == 6'd0 || e_op[5:3] == 3'b001);
  assign w_silent = !(w_op == 6'd0 || w_op[5:3] == 3'b001 || w_op[5:3] == 3'b100);

  always_comb begin
    if (known) begin
      if (idex_instr[25:21] == 5'd0)
        assert_zero_reg_R6: assert (alu_a == rf_rs_data);
      if (c_op == 6'd0 && e_op == 6'd0 && exmem_instr[15:11] != 5'd0 &&
          exmem_instr[15:11] == idex_instr[25:21])
        assert_ex_rr_fwd_R2: assert (alu_a == exmem_result);
      if (c_op == 6'd0 && e_op[5:3] == 3'b100 && w_silent)
        assert_ex_load_blocked_R4: assert (alu_a == rf_rs_data);
      if (c_op == 6'd0 && e_silent && w_op[5:3] == 3'b100 &&
          memwb_instr[20:16] != 5'd0 && memwb_instr[20:16] == idex_instr[25:21])
        assert_wb_load_fwd_R3: assert (alu_a == memwb_result);
      if (c_op != 6'd0)
        assert_imm_operand_R8: assert (alu_b == {{(DATA_W-16){idex_instr[15]}}, idex_instr[15:0]});
      if (c_op[5:3] != 3'b101)
        assert_store_data_R9: assert (store_data == rf_rt_data);
    end
  end

endmodule

bind operand_fwd_unit opfwd_checker #(.DATA_W(DATA_W)) u_chk (
  .idex_instr(idex_instr), .exmem_instr(exmem_instr), .memwb_instr(memwb_instr),
  .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
  .exmem_result(exmem_result), .memwb_result(memwb_result),
  .alu_a(alu_a), .alu_b(alu_b), .store_data(store_data)
);

// File: tb/sim_operand_fwd_unit.sv
module sim_operand_fwd_unit;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic [31:0]   idex_instr, exmem_instr, memwb_instr;
  logic [DW-1:0] rf_rs_data, rf_rt_data, exmem_result, memwb_result;
  logic [DW-1:0] alu_a, alu_b, store_data;
  int            n_chk = 0;
  int            n_bad = 0;
  int            cyc = 0;

  always #10 clk = ~clk;

  operand_fwd_unit #(.DATA_W(DW)) u0 (
    .idex_instr(idex_instr), .exmem_instr(exmem_instr), .memwb_instr(memwb_instr),
    .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
    .exmem_result(exmem_result), .memwb_result(memwb_result),
    .alu_a(alu_a), .alu_b(alu_b), .store_data(store_data)
  );

  function automatic logic [31:0] rr(input int s, input int t, input int d);
    return {6'h00, s[4:0], t[4:0], d[4:0], 11'h020};
  endfunction
  function automatic logic [31:0] it(input logic [5:0] op, input int s, input int t,
                                     input logic [15:0] imm);
    return {op, s[4:0], t[4:0], imm};
  endfunction

  localparam logic [5:0] ADDI = 6'h08, LW = 6'h23, SW = 6'h2B, BEQ = 6'h04,
                         JMP = 6'h02, ODD = 6'h30;
  localparam logic [31:0] NOP = 32'hFC00_0000;

  // expected source codes
  localparam logic [1:0] S_RF = 2'd0, S_EX = 2'd1, S_WB = 2'd2, S_IM = 2'd3;

  typedef struct packed {
    logic [31:0] ci;
    logic [31:0] ei;
    logic [31:0] wi;
    logic [1:0]  ea;
    logic [1:0]  eb;
    logic [1:0]  es;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{rr(3,4,5), rr(1,2,3), NOP, S_EX, S_RF, S_RF, 8'd2},                           // R2 rs
    '{rr(4,3,5), rr(1,2,3), NOP, S_RF, S_EX, S_RF, 8'd2},                           // R2 rt
    '{rr(3,7,1), it(ADDI,9,3,16'h0004), NOP, S_EX, S_RF, S_RF, 8'd3},               // R3 imm rt
    '{rr(3,7,1), it(ADDI,1,8,16'h1800), NOP, S_RF, S_RF, S_RF, 8'd3},               // R3 not rd
    '{rr(3,6,1), NOP, it(LW,2,3,16'h0000), S_WB, S_RF, S_RF, 8'd3},                 // R3 load wb
    '{rr(3,6,1), it(LW,2,3,16'h0000), NOP, S_RF, S_RF, S_RF, 8'd4},                 // R4
    '{rr(3,6,1), rr(1,2,3), rr(4,5,3), S_EX, S_RF, S_RF, 8'd5},                     // R5
    '{rr(3,6,1), it(LW,2,3,16'h0000), rr(4,5,3), S_WB, S_RF, S_RF, 8'd5},           // R5 load ex
    '{rr(0,6,1), rr(1,2,0), rr(1,2,0), S_RF, S_RF, S_RF, 8'd6},                     // R6
    '{it(ADDI,3,4,16'h8005), rr(1,2,3), NOP, S_EX, S_IM, S_RF, 8'd7},               // R7 imm
    '{it(BEQ,3,3,16'h0010), rr(1,2,3), NOP, S_EX, S_IM, S_RF, 8'd7},                // R7 branch
    '{it(JMP,3,3,16'h0040), rr(1,2,3), rr(1,2,3), S_RF, S_IM, S_RF, 8'd7},          // R7 other
    '{it(SW,2,3,16'h0004), NOP, rr(1,2,3), S_RF, S_IM, S_WB, 8'd9},                 // R9 wb
    '{it(SW,3,3,16'hFFFC), it(ADDI,0,3,16'h0001), NOP, S_EX, S_IM, S_EX, 8'd9},     // R9 ex
    '{rr(3,3,1), it(SW,1,3,16'h1800), NOP, S_RF, S_RF, S_RF, 8'd10},                // R10 store
    '{rr(3,3,1), NOP, it(BEQ,3,3,16'h1800), S_RF, S_RF, S_RF, 8'd10},               // R10 branch
    '{rr(6,3,1), NOP, rr(1,2,3), S_RF, S_WB, S_RF, 8'd8},                           // R8
    '{rr(3,3,1), {ODD,5'd1,5'd3,5'd3,11'd0}, NOP, S_RF, S_RF, S_RF, 8'd1}           // R1 odd opcode
  };

  function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      S_EX:    return exmem_result;
      S_WB:    return memwb_result;
      S_IM:    return {{(DW-16){idex_instr[15]}}, idex_instr[15:0]};
      default: return rf;
    endcase
  endfunction

  task automatic check(input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] ci, input logic [31:0] ei, input logic [31:0] wi,
                     input int seed);
    idex_instr   = ci;
    exmem_instr  = ei;
    memwb_instr  = wi;
    rf_rs_data   = 32'h1111_0000 + seed;
    rf_rt_data   = 32'h2222_0000 + seed;
    exmem_result = 32'hEEEE_0000 + seed;
    memwb_result = 32'hBBBB_0000 + seed;
  endtask

  initial begin
    put(32'd0, 32'd0, 32'd0, 0);
    repeat (2) @(negedge clk);
    #2;
    // reset-like state: all-zero words are RR ops on register 0 (R6)
    check("idle alu_a", alu_a, rf_rs_data, 6);
    check("idle alu_b", alu_b, rf_rt_data, 6);
    check("idle store", store_data, rf_rt_data, 9);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      put(VECS[i].ci, VECS[i].ei, VECS[i].wi, 16 * i + 3);
      #2;
      check($sformatf("vec%0d alu_a", i), alu_a, pick(VECS[i].ea, rf_rs_data), VECS[i].req);
      check($sformatf("vec%0d alu_b", i), alu_b, pick(VECS[i].eb, rf_rt_data), VECS[i].req);
      check($sformatf("vec%0d store", i), store_data, pick(VECS[i].es, rf_rt_data), VECS[i].req);
    end

    // R11: output tracks a second data change inside one cycle
    @(negedge clk);
    put(rr(3,4,5), rr(1,2,3), NOP, 7);
    #2;
    check("R11 first", alu_a, 32'hEEEE_0007, 11);
    exmem_result = 32'hA5A5_5A5A;
    #2;
    check("R11 same-cycle", alu_a, 32'hA5A5_5A5A, 11);

    // R5 with MEM/WB load and EX/MEM immediate on same register: newer wins
    @(negedge clk);
    put(rr(9,9,1), it(ADDI,0,9,16'h0001), it(LW,0,9,16'h0000), 9);
    #2;
    check("R5 imm over load a", alu_a, exmem_result, 5);
    check("R5 imm over load b", alu_b, exmem_result, 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual %0d cycles expected <= 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule